// File: doc/BRIEF.md
# Video Sync Recovery and 4:2:2 Component Splitter

This block sits at the pixel-clock edge of a video capture path. It accepts one sample per handshake from an interleaved luma/chroma bus and sends each active sample on with a component tag (Y, Cb or Cr). It also marks the first sample of every line and of every frame and reports the current line index. Samples from blanking intervals and timing words are dropped. Every register is clocked by the externally supplied pixel clock.

Three framing modes can be selected. In embedded mode, line and frame timing is recovered from four-word timing codes carried in the data. In discrete mode, separate horizontal, vertical and field sync inputs that travel with each sample give the timing. In raw mode there is no timing at all. A programmed width and height drive internal counters, every sample is treated as luma, and the last sample of each frame is flagged. Samples are left-justified on the bus, and a width select keeps 8, 10 or 12 significant bits.

Both edges are valid/ready streams. A sample is taken on a clock edge where `in_valid` and `in_ready` are both high. An output beat is held unchanged while `out_valid` is high and `out_ready` is low. During that stall `in_ready` is low, so no sample is lost or repeated. Configuration inputs may only change while no beat is pending.

Top module: `vid_sync_deint`

## Requirements
- R1: While reset is held and on the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: `in_ready` is low exactly while a beat is held by a stall. A held beat keeps every output field stable. Each accepted sample that is emitted appears as one beat on the cycle after it is accepted, in input order, with none lost or duplicated.
- R3: In embedded mode (`cfg_mode`=0), a timing code is the top 8 bits reading 0xFF, 0x00, 0x00 and then an XY word. In the XY word, bit 7 is 1, bit 6 is F, bit 5 is V and bit 4 is H. An XY word with V=0 and H=0 opens an active line. An XY word with H=1 or V=1 closes it. Code words, any sample whose top 8 bits are 0x00 or 0xFF, and all samples outside an active line are not emitted.
- R4: In embedded and discrete modes, the samples of each line are tagged Cb, Y, Cr, Y, repeating from the first sample, with `out_comp` coded as 0=Y, 1=Cb and 2=Cr.
- R5: `out_sol` marks the first emitted sample of a line. `out_sof` marks the first emitted sample of the first line after vertical blanking (an XY word with V=1, or `in_vs` high), and `out_sof` always comes with `out_sol`. `out_line` is 0 on a frame start and rises by 1 on each later line start.
- R6: In discrete mode (`cfg_mode`=1), a sample is active only when both `in_hs` and `in_vs` are low. A line starts at the first active sample after an inactive one.
- R7: `out_field` carries the F bit of the most recent XY word in embedded mode, and the `in_fs` value of the sample in discrete mode. It is 0 in raw mode.
- R8: In raw mode (`cfg_mode`=2 or 3), every accepted sample is emitted as Y. `out_sol` is set in column 0, `out_sof` in column 0 of row 0, and `out_line` equals the row.
- R9: In raw mode, `out_eof` is set only on sample number `cfg_width`×`cfg_height` of a frame (column `cfg_width`-1, row `cfg_height`-1), after which counting restarts at column 0, row 0. `out_eof` is never set in the other modes. Both dimensions are at least 1.
- R10: `cfg_bits` 0, 1 and 2 keep the top 8, 10 and 12 bits of each emitted sample, and the lower bits are forced to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | 0 embedded codes, 1 discrete sync, 2/3 raw |
| cfg_bits | input | 2 | Significant bits: 0→8, 1→10, 2→12 |
| cfg_width | input | CW | Raw-mode samples per line |
| cfg_height | input | CW | Raw-mode lines per frame |
| in_data | input | DW | Left-justified input sample |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Input sample can be taken |
| in_hs | input | 1 | Discrete horizontal blanking, with sample |
| in_vs | input | 1 | Discrete vertical blanking, with sample |
| in_fs | input | 1 | Discrete field flag, with sample |
| out_data | output | DW | Emitted sample, masked to width |
| out_comp | output | 2 | Component tag 0=Y 1=Cb 2=Cr |
| out_sol | output | 1 | First sample of a line |
| out_sof | output | 1 | First sample of a frame |
| out_eof | output | 1 | Last sample of a raw frame |
| out_field | output | 1 | Field flag |
| out_line | output | CW | Line index within the frame |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream takes the beat |

## Verification
Every emitted result appears exactly one clock after its sample is accepted. The bench therefore queues an expected beat when it drives an active sample and pops that beat when it sees `out_valid` and `out_ready` together at a falling edge, so the random stalls only delay a beat and never change its content. Dropped samples (codes, blanking, reserved words) queue nothing, so any extra or missing beat shifts the queue and shows up as mismatches, and a final check requires the queue to be empty. Configuration changes wait until the queue drains, so each beat is checked against the mode it was produced in.

// File: rtl/vsd_pkg.sv
package vsd_pkg;

  typedef enum logic [1:0] {
    MODE_EMB  = 2'd0,
    MODE_SYNC = 2'd1,
    MODE_RAW  = 2'd2
  } vsd_mode_e;

  typedef enum logic [1:0] {
    COMP_Y  = 2'd0,
    COMP_CB = 2'd1,
    COMP_CR = 2'd2
  } vsd_comp_e;

  // timing words are judged on the top byte of the sample
  localparam int unsigned CODE_W = 8;

  // 4:2:2 order within a line: Cb, Y, Cr, Y
  function automatic vsd_comp_e comp_of_phase(input logic [1:0] ph);
    case (ph)
      2'd0:    return COMP_CB;
      2'd2:    return COMP_CR;
      default: return COMP_Y;
    endcase
  endfunction

endpackage

// File: rtl/vsd_code_det.sv
module vsd_code_det
  import vsd_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [DW-1:0] smp,
  output logic          is_code,
  output logic          is_rsvd,
  output logic          xy_f,
  output logic          xy_v,
  output logic          xy_h
);
  localparam int CODE_LSB = DW - CODE_W;

  logic [CODE_W-1:0] top;
  logic [CODE_W-1:0] h1_q, h2_q, h3_q;

  assign top = smp[DW-1:CODE_LSB];

  // last three accepted top bytes, newest in h1
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h1_q <= '0;
      h2_q <= '0;
      h3_q <= '0;
    end else if (adv) begin
      h3_q <= h2_q;
      h2_q <= h1_q;
      h1_q <= top;
    end
  end

  assign is_code = (h3_q == '1) && (h2_q == '0) && (h1_q == '0);
  assign is_rsvd = (top == '1) || (top == '0);
  assign xy_f    = top[6];
  assign xy_v    = top[5];
  assign xy_h    = top[4];

endmodule

// File: rtl/vsd_raw_cnt.sv
module vsd_raw_cnt #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [CW-1:0] cfg_width,
  input  logic [CW-1:0] cfg_height,
  output logic          col_first,
  output logic          row_first,
  output logic          frame_last,
  output logic [CW-1:0] row
);
  logic [CW-1:0] col_q, row_q;
  logic          col_last, row_last;

  assign col_last = (col_q == cfg_width - 1'b1);
  assign row_last = (row_q == cfg_height - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
    end else if (adv) begin
      if (col_last) begin
        col_q <= '0;
        row_q <= row_last ? '0 : row_q + 1'b1;
      end else begin
        col_q <= col_q + 1'b1;
      end
    end
  end

  assign col_first  = (col_q == '0);
  assign row_first  = (row_q == '0);
  assign frame_last = col_last && row_last;
  assign row        = row_q;

endmodule

// File: rtl/vsd_framer.sv
module vsd_framer
  import vsd_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [1:0]    mode,
  input  logic          is_code,
  input  logic          is_rsvd,
  input  logic          xy_f,
  input  logic          xy_v,
  input  logic          xy_h,
  input  logic          in_hs,
  input  logic          in_vs,
  input  logic          in_fs,
  input  logic          raw_col_first,
  input  logic          raw_row_first,
  input  logic          raw_last,
  input  logic [CW-1:0] raw_row,
  output logic          emit,
  output vsd_comp_e     comp,
  output logic          sol,
  output logic          sof,
  output logic          eof,
  output logic          field,
  output logic [CW-1:0] line
);
  logic          active_q, sol_pend_q, sof_pend_q, vb_seen_q, was_act_q, field_q;
  logic [1:0]    phase_q;
  logic [CW-1:0] line_q;

  logic       raw_mode, sync_mode, emb_mode, sync_act, field_now;
  logic [1:0] ph_use;

  assign raw_mode  = mode[1];
  assign sync_mode = (mode == MODE_SYNC);
  assign emb_mode  = (mode == MODE_EMB);
  assign sync_act  = !in_hs && !in_vs;

  always_comb begin
    emit      = 1'b0;
    sol       = 1'b0;
    sof       = 1'b0;
    eof       = 1'b0;
    field_now = field_q;
    if (raw_mode) begin
      emit = 1'b1;
      sol  = raw_col_first;
      sof  = raw_col_first && raw_row_first;
      eof  = raw_last;
    end else if (sync_mode) begin
      emit      = sync_act;
      sol       = sync_act && !was_act_q;
      sof       = sync_act && !was_act_q && vb_seen_q;
      field_now = in_fs;
    end else begin
      emit = active_q && !is_code && !is_rsvd;
      sol  = emit && sol_pend_q;
      sof  = emit && sof_pend_q;
      if (is_code) field_now = xy_f;
    end
  end

  assign ph_use = sol ? 2'd0 : phase_q;
  assign comp   = raw_mode ? COMP_Y : comp_of_phase(ph_use);
  assign field  = raw_mode ? 1'b0 : field_now;
  assign line   = raw_mode ? raw_row :
                  sof      ? '0 :
                  sol      ? line_q + 1'b1 : line_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q   <= 1'b0;
      sol_pend_q <= 1'b0;
      sof_pend_q <= 1'b0;
      vb_seen_q  <= 1'b0;
      was_act_q  <= 1'b0;
      field_q    <= 1'b0;
      phase_q    <= 2'd0;
      line_q     <= '0;
    end else if (adv) begin
      field_q <= field_now;
      if (emit && !raw_mode) begin
        phase_q <= ph_use + 2'd1;
        line_q  <= line;
      end
      if (sync_mode) begin
        was_act_q <= sync_act;
        if (in_vs)    vb_seen_q <= 1'b1;
        else if (sof) vb_seen_q <= 1'b0;
      end
      if (emb_mode) begin
        if (is_code) begin
          if (xy_v) begin
            vb_seen_q <= 1'b1;
            active_q  <= 1'b0;
          end else if (xy_h) begin
            active_q <= 1'b0;
          end else begin
            active_q   <= 1'b1;
            sol_pend_q <= 1'b1;
            if (vb_seen_q) begin
              sof_pend_q <= 1'b1;
              vb_seen_q  <= 1'b0;
            end
          end
        end else if (emit) begin
          sol_pend_q <= 1'b0;
          sof_pend_q <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/vid_sync_deint.sv
module vid_sync_deint
  import vsd_pkg::*;
#(
  parameter int DW = 12,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cfg_mode,
  input  logic [1:0]    cfg_bits,
  input  logic [CW-1:0] cfg_width,
  input  logic [CW-1:0] cfg_height,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_hs,
  input  logic          in_vs,
  input  logic          in_fs,
  output logic [DW-1:0] out_data,
  output logic [1:0]    out_comp,
  output logic          out_sol,
  output logic          out_sof,
  output logic          out_eof,
  output logic          out_field,
  output logic [CW-1:0] out_line,
  output logic          out_valid,
  input  logic          out_ready
);
  localparam int MAX_BITS = (DW < 12) ? DW : 12;

  function automatic logic [DW-1:0] width_mask(input logic [1:0] sel);
    logic [DW-1:0] m;
    int keep;
    keep = (sel == 2'd0) ? 8 : (sel == 2'd1) ? 10 : MAX_BITS;
    for (int i = 0; i < DW; i++) m[DW-1-i] = (i < keep);
    return m;
  endfunction

  logic accept;
  logic is_code, is_rsvd, xy_f, xy_v, xy_h;
  logic raw_col_first, raw_row_first, raw_last;
  logic [CW-1:0] raw_row;
  logic emit, sol, sof, eof, field;
  vsd_comp_e comp;
  logic [CW-1:0] line;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  vsd_code_det #(.DW(DW)) u_code (
    .clk(clk), .rst_n(rst_n), .adv(accept), .smp(in_data),
    .is_code(is_code), .is_rsvd(is_rsvd),
    .xy_f(xy_f), .xy_v(xy_v), .xy_h(xy_h)
  );

  vsd_raw_cnt #(.CW(CW)) u_raw (
    .clk(clk), .rst_n(rst_n), .adv(accept && cfg_mode[1]),
    .cfg_width(cfg_width), .cfg_height(cfg_height),
    .col_first(raw_col_first), .row_first(raw_row_first),
    .frame_last(raw_last), .row(raw_row)
  );

  vsd_framer #(.CW(CW)) u_frm (
    .clk(clk), .rst_n(rst_n), .adv(accept), .mode(cfg_mode),
    .is_code(is_code), .is_rsvd(is_rsvd),
    .xy_f(xy_f), .xy_v(xy_v), .xy_h(xy_h),
    .in_hs(in_hs), .in_vs(in_vs), .in_fs(in_fs),
    .raw_col_first(raw_col_first), .raw_row_first(raw_row_first),
    .raw_last(raw_last), .raw_row(raw_row),
    .emit(emit), .comp(comp), .sol(sol), .sof(sof), .eof(eof),
    .field(field), .line(line)
  );

  // single output stage; held while the consumer stalls
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_comp  <= 2'd0;
      out_sol   <= 1'b0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
      out_field <= 1'b0;
      out_line  <= '0;
    end else if (accept) begin
      out_valid <= emit;
      if (emit) begin
        out_data  <= in_data & width_mask(cfg_bits);
        out_comp  <= comp;
        out_sol   <= sol;
        out_sof   <= sof;
        out_eof   <= eof;
        out_field <= field;
        out_line  <= line;
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/vsd_checker.sv
module vsd_checker #(
  parameter int DW = 12,
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    cfg_mode,
  input logic [1:0]    cfg_bits,
  input logic          in_ready,
  input logic [DW-1:0] out_data,
  input logic [1:0]    out_comp,
  input logic          out_sol,
  input logic          out_sof,
  input logic          out_eof,
  input logic [CW-1:0] out_line,
  input logic          out_valid,
  input logic          out_ready
);
  localparam logic [DW-1:0] LOW_OF_8 = {DW{1'b1}} >> 8;

  AST_RST_IDLE: assert property (@(posedge clk) !rst_n |=> !out_valid); // R1

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_comp)
      && $stable(out_sol) && $stable(out_sof) && $stable(out_line)); // R2

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R2

  AST_LINE_START_CB: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sol && !cfg_mode[1] |-> out_comp == 2'd1); // R4

  AST_SOF_WITH_SOL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sof |-> out_sol && out_line == '0); // R5

  AST_RAW_LUMA: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cfg_mode[1] |-> out_comp == 2'd0); // R8

  AST_EOF_RAW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_eof |-> cfg_mode[1]); // R9

  AST_MASK_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cfg_bits == 2'd0 |-> (out_data & LOW_OF_8) == '0); // R10

endmodule

bind vid_sync_deint vsd_checker #(.DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_bits(cfg_bits),
  .in_ready(in_ready), .out_data(out_data), .out_comp(out_comp),
  .out_sol(out_sol), .out_sof(out_sof), .out_eof(out_eof),
  .out_line(out_line), .out_valid(out_valid), .out_ready(out_ready)
);

// File: tb/vid_sync_deint_bench.sv
module vid_sync_deint_bench;
  localparam int DW = 12;
  localparam int CW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [1:0]    cfg_mode = 2'd0, cfg_bits = 2'd2;
  logic [CW-1:0] cfg_width = 12'd1, cfg_height = 12'd1;
  logic [DW-1:0] in_data = '0;
  logic          in_valid = 1'b0, in_hs = 1'b0, in_vs = 1'b0, in_fs = 1'b0;
  logic          in_ready, out_ready = 1'b1;
  logic [DW-1:0] out_data;
  logic [1:0]    out_comp;
  logic          out_sol, out_sof, out_eof, out_field, out_valid;
  logic [CW-1:0] out_line;

  vid_sync_deint #(.DW(DW), .CW(CW)) u_vid_sync_deint (.*);

  typedef struct packed {
    logic [DW-1:0] d;
    logic [1:0]    c;
    logic          sol, sof, eof, fld;
    logic [CW-1:0] ln;
  } beat_t;

  beat_t exp_q[$];
  beat_t got;
  int checks = 0, errors = 0, cyc = 0, kval = 0;
  logic [7:0] lfsr = 8'h5a;
  logic stall_on = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // consumer stalls from an LFSR, changed just after each rising edge
  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready <= !stall_on || (lfsr[0] | lfsr[2]);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R2 watchdog actual %0d expected below 150000", cyc);
      finish_run();
    end
  end

  // scoreboard: one expected beat per handshake
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(0, "R2", "extra beat", out_data, 0);
      end else begin
        got = exp_q.pop_front();
        chk(out_data == got.d, "R10", "data", out_data, got.d);
        chk(out_comp == got.c, "R4", "comp", out_comp, got.c);
        chk(out_sol == got.sol, "R5", "sol", out_sol, got.sol);
        chk(out_sof == got.sof, "R5", "sof", out_sof, got.sof);
        chk(out_line == got.ln, "R5", "line", out_line, got.ln);
        chk(out_eof == got.eof, "R9", "eof", out_eof, got.eof);
        chk(out_field == got.fld, "R7", "field", out_field, got.fld);
      end
    end
  end

  function automatic logic [DW-1:0] msk(input logic [DW-1:0] d, input int bits);
    int drop;
    drop = 12 - (8 + 2 * bits);
    return (d >> drop) << drop;
  endfunction

  // data values whose top byte is never 0x00 or 0xFF
  function automatic logic [DW-1:0] nextval();
    kval++;
    return DW'(12'h100 + ((kval * 37) % 12'hD00));
  endfunction

  task automatic send(input logic [DW-1:0] d, input logic hs = 0,
                      input logic vs = 0, input logic fs = 0);
    bit ok;
    @(negedge clk);
    in_data = d; in_hs = hs; in_vs = vs; in_fs = fs; in_valid = 1'b1;
    forever begin
      ok = in_ready;
      @(posedge clk);
      if (ok) break;
      @(negedge clk);
    end
  endtask

  task automatic idle_drain();
    @(negedge clk);
    in_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic push(input logic [DW-1:0] d, input logic [1:0] c, input logic sol,
                      input logic sof, input logic eof, input logic fld, input int ln);
    beat_t b;
    b.d = d; b.c = c; b.sol = sol; b.sof = sof; b.eof = eof; b.fld = fld; b.ln = CW'(ln);
    exp_q.push_back(b);
  endtask

  function automatic logic [1:0] comp_at(input int s);
    return (s % 4 == 0) ? 2'd1 : (s % 4 == 2) ? 2'd2 : 2'd0;
  endfunction

  task automatic emb_code(input logic f, input logic v, input logic h);
    send(12'hFFF); send(12'h000); send(12'h000);
    send({1'b1, f, v, h, 8'h00});
  endtask

  // R3: one blanking line, then active lines framed by start/end codes
  task automatic emb_frame(input logic f, input int nlines, input int nsmp, input int bits);
    logic [DW-1:0] d;
    emb_code(f, 1'b1, 1'b1);
    send(12'h800); send(12'h800);
    emb_code(f, 1'b1, 1'b0);
    for (int s = 0; s < 4; s++) send(nextval());
    for (int ln = 0; ln < nlines; ln++) begin
      emb_code(f, 1'b0, 1'b0);
      for (int s = 0; s < nsmp; s++) begin
        d = nextval();
        push(msk(d, bits), comp_at(s), s == 0, s == 0 && ln == 0, 1'b0, f, ln);
        send(d);
      end
      emb_code(f, 1'b0, 1'b1);
      send(12'h800); send(12'hFF0); send(12'h00F);
    end
  endtask

  // R6: discrete sync, blanking when either sync input is high
  task automatic sync_frame(input logic f, input int nlines, input int nsmp, input int bits);
    logic [DW-1:0] d;
    for (int l = 0; l < 2; l++)
      for (int s = 0; s < 9; s++) send(nextval(), s < 3, 1'b1, f);
    for (int ln = 0; ln < nlines; ln++) begin
      for (int s = 0; s < 3; s++) send(nextval(), 1'b1, 1'b0, f);
      for (int s = 0; s < nsmp; s++) begin
        d = nextval();
        push(msk(d, bits), comp_at(s), s == 0, s == 0 && ln == 0, 1'b0, f, ln);
        send(d, 1'b0, 1'b0, f);
      end
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1", "in_ready in reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

    // embedded codes, two frames of opposite field, then 10-bit width
    stall_on = 1'b1;
    cfg_mode = 2'd0; cfg_bits = 2'd2;
    emb_frame(1'b0, 3, 8, 2);
    emb_frame(1'b1, 2, 6, 2);
    idle_drain();
    cfg_bits = 2'd1;
    emb_frame(1'b0, 2, 8, 1);
    idle_drain();

    // discrete sync, 8-bit width
    cfg_mode = 2'd1; cfg_bits = 2'd0;
    sync_frame(1'b1, 3, 6, 0);
    sync_frame(1'b0, 2, 5, 0);
    idle_drain();

    // raw sweep over small sizes, R8 and R9, width select rotating
    cfg_mode = 2'd2;
    for (int w = 1; w <= 4; w++) begin
      for (int h = 1; h <= 3; h++) begin
        idle_drain();
        cfg_width = CW'(w); cfg_height = CW'(h); cfg_bits = 2'((w + h) % 3);
        for (int fr = 0; fr < 2; fr++)
          for (int y = 0; y < h; y++)
            for (int x = 0; x < w; x++) begin
              logic [DW-1:0] d;
              d = nextval();
              push(msk(d, (w + h) % 3), 2'd0, x == 0, x == 0 && y == 0,
                   x == w - 1 && y == h - 1, 1'b0, y);
              send(d);
            end
      end
    end
    idle_drain();
    stall_on = 1'b0;
    chk(exp_q.size() == 0, "R2", "beats outstanding", exp_q.size(), 0);
    chk(out_valid == 1'b0, "R2", "idle out_valid", out_valid, 0);
    finish_run();
  end

endmodule